// File: doc/BRIEF.md
# Link Power Mode Controller

This block chooses the operating mode of a serial display link bridge: off, waiting, or running. A low level on the shutdown input forces the off mode and turns off every function. When that input is high the block waits in a low-power waiting mode. It leaves the waiting mode by itself once it sees the incoming pixel clock toggling. The pixel clock is never used as a clock inside the block. A free-running reference clock samples it as data, and the block counts its level changes in fixed windows of reference cycles.

On entering the running mode the PLL is switched on first. The datapath and the output drivers are switched on only after a fixed lock-wait interval. If the pixel clock then stops toggling for a long enough run of reference cycles, the block falls back to waiting with everything off. The mode is also reported as a 2-bit code so that the rest of the bridge can follow it.

Top module: `link_pwr_ctrl`

## Requirements
- R1: While reset is asserted and after it is released with the shutdown input low, `mode_o` is 0 (off) and `pll_en_o`, `dp_en_o` and `drv_en_o` are all low.
- R2: A low level on `shdn_ni` forces the off mode from any mode at the first reference edge after it goes low. All enables are low from then on, and pixel-clock activity has no effect while the input stays low.
- R3: After `shdn_ni` rises, the shutdown synchroniser takes two reference edges. The block shows waiting mode (`mode_o` = 1) after the third edge, with all enables low.
- R4: The activity detector runs in 16-cycle windows. The first window starts when the synchronised shutdown input goes high. A window in which the sampled pixel clock changes level at least 4 times moves a waiting block into lock-wait at the edge after the window ends. Lock-wait reports `mode_o` = 2, with `pll_en_o` high and `dp_en_o`/`drv_en_o` low. Exactly 4 changes is enough.
- R5: A window with fewer than 4 pixel-clock level changes leaves the block in waiting mode.
- R6: `dp_en_o` and `drv_en_o` rise together exactly 32 reference cycles after `pll_en_o` rises, while `mode_o` stays 2.
- R7: In lock-wait or running mode, 64 consecutive reference cycles with no pixel-clock level change return the block to waiting mode (`mode_o` = 1) with all enables low.
- R8: A shutdown that lands in the same cycle as an activity verdict, an idle timeout or the end of the lock wait wins. The next mode is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| shdn_ni | input | 1 | Asynchronous shutdown request, active low |
| pclk_i | input | 1 | Pixel clock, sampled as data |
| pll_en_o | output | 1 | PLL enable |
| dp_en_o | output | 1 | Datapath enable |
| drv_en_o | output | 1 | Output driver enable |
| mode_o | output | 2 | Mode code: 0 off, 1 waiting, 2 running (lock-wait or full) |

## Verification
Two events can fall in the same reference cycle: a falling shutdown input, and the detector's end-of-window verdict (or the end of the lock wait). The bench sweeps the cycle in which shutdown drops across every position of the 16-cycle window while the pixel clock toggles fast. It then repeats the sweep against a running link. A behavioural model computes the mode and enables from the input history and is compared on every clock. Under that comparison a shutdown that coincides with a verdict must give the off mode, and never a lock-wait cycle.

// File: rtl/link_pwr_pkg.sv
package link_pwr_pkg;
  typedef enum logic [1:0] {
    PM_OFF  = 2'd0,
    PM_WAIT = 2'd1,
    PM_LOCK = 2'd2,
    PM_RUN  = 2'd3
  } pm_state_e;

  localparam logic [1:0] MODE_OFF  = 2'd0;
  localparam logic [1:0] MODE_WAIT = 2'd1;
  localparam logic [1:0] MODE_RUN  = 2'd2;
endpackage

// File: rtl/lp_sync.sv
module lp_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg[0] <= '0;
        else         stg[0] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg[i] <= '0;
        else         stg[i] <= stg[i-1];
      end
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/lp_clk_activity.sv
module lp_clk_activity #(
  parameter int WIN       = 16,
  parameter int MIN_EDGES = 4,
  parameter int IDLE_LIM  = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic pclk_s_i,
  output logic act_o,
  output logic idle_o
);
  localparam int WW = (WIN > 1) ? $clog2(WIN) : 1;
  localparam int EW = $clog2(MIN_EDGES + 1);
  localparam int IW = $clog2(IDLE_LIM + 1);
  localparam logic [WW-1:0] WLAST = WW'(WIN - 1);
  localparam logic [EW-1:0] EMIN  = EW'(MIN_EDGES);
  localparam logic [IW-1:0] ILIM  = IW'(IDLE_LIM);

  logic          pclk_d_q;
  logic          pc_edge;
  logic [WW-1:0] wcnt_q;
  logic [EW-1:0] ecnt_q, ecnt_nxt;
  logic [IW-1:0] idle_q;
  logic          act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pclk_d_q <= 1'b0;
    else         pclk_d_q <= pclk_s_i;
  end

  assign pc_edge  = pclk_s_i ^ pclk_d_q;
  assign ecnt_nxt = (ecnt_q == EMIN) ? ecnt_q : ecnt_q + EW'(pc_edge);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wcnt_q <= '0;
      ecnt_q <= '0;
      act_q  <= 1'b0;
      idle_q <= '0;
    end else if (!en_i) begin
      wcnt_q <= '0;
      ecnt_q <= '0;
      act_q  <= 1'b0;
      idle_q <= '0;
    end else begin
      if (wcnt_q == WLAST) begin
        wcnt_q <= '0;
        ecnt_q <= '0;
        act_q  <= (ecnt_nxt == EMIN);
      end else begin
        wcnt_q <= wcnt_q + 1'b1;
        ecnt_q <= ecnt_nxt;
        act_q  <= 1'b0;
      end
      if (pc_edge)             idle_q <= '0;
      else if (idle_q != ILIM) idle_q <= idle_q + 1'b1;
    end
  end

  assign act_o  = act_q;
  assign idle_o = (idle_q == ILIM);

  // verdict only at a window boundary
  p_act_at_window_end_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_q |-> $past(wcnt_q) == WLAST);

  p_idle_holds_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_o && en_i && !pc_edge) |=> idle_o);

  p_edge_clears_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && pc_edge) |=> !idle_o);
endmodule

// File: rtl/lp_mode_fsm.sv
module lp_mode_fsm
  import link_pwr_pkg::*;
#(
  parameter int LOCK_CYC = 32
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic       act_i,
  input  logic       idle_i,
  output logic       pll_en_o,
  output logic       dp_en_o,
  output logic       drv_en_o,
  output logic [1:0] mode_o
);
  localparam int LW = (LOCK_CYC > 1) ? $clog2(LOCK_CYC) : 1;
  localparam logic [LW-1:0] LLAST = LW'(LOCK_CYC - 1);

  pm_state_e     state_q, state_d;
  logic [LW-1:0] lcnt_q;

  always_comb begin
    state_d = state_q;
    if (!run_i) begin
      state_d = PM_OFF;
    end else begin
      unique case (state_q)
        PM_OFF:  state_d = PM_WAIT;
        PM_WAIT: if (act_i) state_d = PM_LOCK;
        PM_LOCK: begin
          if (idle_i)               state_d = PM_WAIT;
          else if (lcnt_q == LLAST) state_d = PM_RUN;
        end
        PM_RUN:  if (idle_i) state_d = PM_WAIT;
        default: state_d = PM_OFF;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PM_OFF;
      lcnt_q  <= '0;
    end else begin
      state_q <= state_d;
      lcnt_q  <= (state_q == PM_LOCK && state_d == PM_LOCK) ? lcnt_q + 1'b1 : '0;
    end
  end

  always_comb begin
    pll_en_o = 1'b0;
    dp_en_o  = 1'b0;
    drv_en_o = 1'b0;
    mode_o   = MODE_OFF;
    unique case (state_q)
      PM_OFF:  mode_o = MODE_OFF;
      PM_WAIT: mode_o = MODE_WAIT;
      PM_LOCK: begin
        mode_o   = MODE_RUN;
        pll_en_o = 1'b1;
      end
      PM_RUN: begin
        mode_o   = MODE_RUN;
        pll_en_o = 1'b1;
        dp_en_o  = 1'b1;
        drv_en_o = 1'b1;
      end
      default: mode_o = MODE_OFF;
    endcase
  end

  p_shdn_forces_off_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (mode_o == MODE_OFF && !pll_en_o));

  p_lock_entry_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && state_q == PM_WAIT && act_i) |=> (pll_en_o && !dp_en_o));

  p_no_spurious_lock_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PM_WAIT && !act_i) |=> !pll_en_o);

  p_dp_after_pll_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dp_en_o) |-> $past(pll_en_o));

  p_idle_drop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && idle_i && (state_q == PM_LOCK || state_q == PM_RUN)) |=>
      (mode_o == MODE_WAIT && !pll_en_o));

  p_shdn_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && act_i) |=> !pll_en_o);
endmodule

// File: rtl/link_pwr_ctrl.sv
module link_pwr_ctrl #(
  parameter int SYNC_STAGES = 2,
  parameter int WIN         = 16,
  parameter int MIN_EDGES   = 4,
  parameter int IDLE_LIM    = 64,
  parameter int LOCK_CYC    = 32
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       shdn_ni,
  input  logic       pclk_i,
  output logic       pll_en_o,
  output logic       dp_en_o,
  output logic       drv_en_o,
  output logic [1:0] mode_o
);
  logic shdn_clr_n;
  logic run_s;
  logic pclk_s;
  logic act, idle;

  // shutdown clears the synchroniser at once; release is synchronised
  assign shdn_clr_n = rst_ni & shdn_ni;

  lp_sync #(.W(1), .STAGES(SYNC_STAGES)) u_shdn_sync (
    .clk_i (clk_i),
    .rst_ni(shdn_clr_n),
    .d_i   (1'b1),
    .q_o   (run_s)
  );

  lp_sync #(.W(1), .STAGES(SYNC_STAGES)) u_pclk_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pclk_i),
    .q_o   (pclk_s)
  );

  lp_clk_activity #(
    .WIN      (WIN),
    .MIN_EDGES(MIN_EDGES),
    .IDLE_LIM (IDLE_LIM)
  ) u_activity (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (run_s),
    .pclk_s_i(pclk_s),
    .act_o   (act),
    .idle_o  (idle)
  );

  lp_mode_fsm #(.LOCK_CYC(LOCK_CYC)) u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run_s),
    .act_i   (act),
    .idle_i  (idle),
    .pll_en_o(pll_en_o),
    .dp_en_o (dp_en_o),
    .drv_en_o(drv_en_o),
    .mode_o  (mode_o)
  );
endmodule

// File: tb/link_pwr_ctrl_bench.sv
module link_pwr_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       shdn_ni = 1'b0;
  logic       pclk_i = 1'b0;
  logic       pll_en_o, dp_en_o, drv_en_o;
  logic [1:0] mode_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int pclk_half = 0;
  int pclk_cnt = 0;
  string cur_req = "R1";

  // model state
  int m_s1, m_s2, m_p1, m_p2, m_p3;
  int m_w, m_e, m_idle, m_act, m_st, m_lc;

  link_pwr_ctrl u_link_pwr_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .shdn_ni(shdn_ni), .pclk_i(pclk_i),
    .pll_en_o(pll_en_o), .dp_en_o(dp_en_o), .drv_en_o(drv_en_o), .mode_o(mode_o)
  );

  always #4 clk = ~clk;

  always @(negedge clk) begin
    if (pclk_half != 0) begin
      pclk_cnt++;
      if (pclk_cnt >= pclk_half) begin
        pclk_i   <= ~pclk_i;
        pclk_cnt = 0;
      end
    end else pclk_cnt = 0;
  end

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_mode(int st);
    return (st == 0) ? 0 : (st == 1) ? 1 : 2;
  endfunction

  always @(posedge clk) begin
    int en, pe, act_old, idle_old, st_old, lc_old, e2;
    #1;
    if (!rst_ni) begin
      m_s1 = 0; m_s2 = 0; m_p1 = 0; m_p2 = 0; m_p3 = 0;
      m_w = 0; m_e = 0; m_idle = 0; m_act = 0; m_st = 0; m_lc = 0;
    end else begin
      if (!shdn_ni) begin m_s1 = 0; m_s2 = 0; end
      en = m_s2; pe = m_p2 ^ m_p3;
      act_old = m_act; idle_old = (m_idle >= 64); st_old = m_st; lc_old = m_lc;
      m_s2 = m_s1; m_s1 = shdn_ni ? 1 : 0;
      if (!shdn_ni) begin m_s1 = 0; m_s2 = 0; end
      m_p3 = m_p2; m_p2 = m_p1; m_p1 = pclk_i;
      if (!en) begin
        m_w = 0; m_e = 0; m_idle = 0; m_act = 0;
      end else begin
        e2 = (m_e + pe > 4) ? 4 : m_e + pe;
        if (m_w == 15) begin m_act = (e2 >= 4); m_e = 0; m_w = 0; end
        else begin m_act = 0; m_e = e2; m_w++; end
        if (pe) m_idle = 0; else if (m_idle < 64) m_idle++;
      end
      if (!en) m_st = 0;
      else case (st_old)
        0: m_st = 1;
        1: if (act_old) m_st = 2;
        2: if (idle_old) m_st = 1; else if (lc_old == 31) m_st = 3;
        default: if (idle_old) m_st = 1;
      endcase
      m_lc = (st_old == 2 && m_st == 2) ? lc_old + 1 : 0;
    end
    check(cur_req, "model mode_o", int'(mode_o), exp_mode(m_st));
    check(cur_req, "model pll_en_o", int'(pll_en_o), (m_st >= 2) ? 1 : 0);
    check(cur_req, "model dp_en_o", int'(dp_en_o), (m_st == 3) ? 1 : 0);
    check(cur_req, "model drv_en_o", int'(drv_en_o), (m_st == 3) ? 1 : 0);
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      checks++; errors++;
      $display("FAIL R_all watchdog actual=%0d expected<50000", cycles);
      finish_run();
    end
  end

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int n;
    cur_req = "R1";
    wait_cyc(3);
    check("R1", "mode in reset", int'(mode_o), 0);
    check("R1", "pll in reset", int'(pll_en_o), 0);
    rst_ni = 1'b1;
    wait_cyc(3);
    check("R1", "mode after reset", int'(mode_o), 0);
    check("R1", "dp after reset", int'(dp_en_o), 0);

    cur_req = "R3";
    shdn_ni = 1'b1;
    wait_cyc(2);
    check("R3", "mode after two edges", int'(mode_o), 0);
    wait_cyc(1);
    check("R3", "mode after third edge", int'(mode_o), 1);
    check("R3", "pll in waiting", int'(pll_en_o), 0);

    cur_req = "R5";
    pclk_half = 6;
    wait_cyc(120);
    check("R5", "mode with slow pixel clock", int'(mode_o), 1);

    cur_req = "R4";
    pclk_half = 4;
    n = 0;
    while (!pll_en_o && n < 60) begin wait_cyc(1); n++; end
    check("R4", "pll rises at exactly 4 changes per window", int'(pll_en_o), 1);
    check("R4", "mode in lock-wait", int'(mode_o), 2);
    check("R4", "dp low in lock-wait", int'(dp_en_o), 0);

    cur_req = "R6";
    n = 0;
    while (!dp_en_o && n < 60) begin wait_cyc(1); n++; end
    check("R6", "lock-wait length", n, 32);
    check("R6", "drv with dp", int'(drv_en_o), 1);

    cur_req = "R7";
    pclk_half = 0;
    wait_cyc(60);
    check("R7", "still running before timeout", int'(mode_o), 2);
    wait_cyc(15);
    check("R7", "waiting after timeout", int'(mode_o), 1);
    check("R7", "pll off after timeout", int'(pll_en_o), 0);

    cur_req = "R2";
    pclk_half = 2;
    n = 0;
    while (!dp_en_o && n < 100) begin wait_cyc(1); n++; end
    check("R2", "running before shutdown", int'(dp_en_o), 1);
    shdn_ni = 1'b0;
    wait_cyc(1);
    check("R2", "off one edge after shutdown", int'(mode_o), 0);
    check("R2", "dp off after shutdown", int'(dp_en_o), 0);
    wait_cyc(40);
    check("R2", "pixel clock ignored in shutdown", int'(pll_en_o), 0);

    cur_req = "R8";
    for (int off = 0; off < 16; off++) begin
      shdn_ni = 1'b1;
      wait_cyc(20 + off);
      shdn_ni = 1'b0;
      wait_cyc(2);
      check("R8", "off after shutdown near verdict", int'(mode_o), 0);
    end
    for (int off = 0; off < 8; off++) begin
      shdn_ni = 1'b1;
      wait_cyc(50 + 2 * off);
      shdn_ni = 1'b0;
      wait_cyc(2);
      check("R8", "off after shutdown near lock end", int'(pll_en_o), 0);
    end
    pclk_half = 0;
    wait_cyc(4);
    finish_run();
  end
endmodule